// File: doc/BRIEF.md
# External Data Bus Transfer Sequencer

This block sits between a single-cycle 8-bit processor core and an external data RAM. It runs from a clock at twice the core rate. Two of its clock periods make up one machine cycle, and the output `second_half` tells the core which half is current. Every output comes straight from a flop, so the half-cycle address strobe pulse never passes through combinational gating.

When no external transfer is running, the block paces the address strobe from the instruction stream. At the start of each instruction it samples the instruction length. It raises the strobe only in the first half of that instruction's first machine cycle.

A transfer request from the core is accepted at a machine-cycle boundary. The block then drives an address phase, a stretched read or write strobe phase and a closing cycle, over a multiplexed low address/data byte and a separate high address byte. The length of the strobe phase comes from a 3-bit wait-state register, which the core reaches through a special-function-register port at address 9FH.

Top module: `xdata_sequencer`

## Requirements
- R1: While reset is held, and on the first cycle after its release, the outputs read: `ale`=0, `rd_n`=`wr_n`=1, `busy`=0, `done`=0, `ad_oe`=0, `ad_o`=0, `a_hi`=0, `rdata`=0, `sfr_rdata`=0, `second_half`=0.
- R2: A machine cycle is two clocks. `second_half` is 0 in the first clock and 1 in the second, and the two alternate without a break.
- R3: When idle and given an instruction length of 1, `ale` is 1 in the first half of every machine cycle and 0 in the second half.
- R4: An instruction length is sampled at the boundary where an instruction begins. For a length L of 2 or more, `ale` is 1 only in the first half of the first of the L cycles, and 0 for the rest. Lengths 0 and 1 both mean one cycle.
- R5: A transfer with wait count n holds `busy` for exactly 4+n machine cycles (2·(4+n) clocks). `done` is 1 for the whole of the last of those cycles.
- R6: The transfer order is fixed. In cycle 1, `ale` is 1 in the first half, `ad_o` carries address bits 7:0 with `ad_oe`=1, and `a_hi` carries address bits 15:8 for the whole transfer. In cycles 2 to 3+n, the strobe for the transfer direction is low. In cycle 4+n, both strobes are high. Outside a transfer, `a_hi` is 0 and no strobe is low.
- R7: In a write (`req_we`=1), `wr_n` is low during the strobe cycles, `rd_n` stays high, and `ad_o` carries the write byte with `ad_oe`=1 from cycle 2 through cycle 4+n.
- R8: In a read (`req_we`=0), `rd_n` is low during the strobe cycles and `ad_oe` is 0 from cycle 2 onward. `rdata` takes the value of `ad_i` present at the end of cycle 3+n, and keeps it until the next read.
- R9: The wait register sits at SFR address 9FH and resets to 0. A write stores only bits 2:0, and reads return bits 7:3 as 0. Writes to other addresses leave it unchanged.
- R10: A request is taken at the first boundary where `busy` is low. A request raised during a transfer is held, not lost. It starts one idle machine cycle after the cycle in which `done` was 1.
- R11: The wait count is captured when a transfer starts. Rewriting the register during a transfer changes only later transfers.
- R12: `rd_n` and `wr_n` are never low together, and `ale` is never 1 while `second_half` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the machine-cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| second_half | output | 1 | 1 during the second clock of a machine cycle |
| insn_len | input | 3 | Cycle count of the instruction beginning at this boundary |
| req | input | 1 | Transfer request, held until `busy` is seen high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | External data address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Final cycle of a transfer |
| rdata | output | 8 | Byte captured by the latest read |
| sfr_we | input | 1 | SFR write enable |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Wait register contents, upper bits zero |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ad_o | output | 8 | Multiplexed low address / data out |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| ad_i | input | 8 | Multiplexed data in |
| a_hi | output | 8 | High address byte |

## Verification
A wrong cycle counter or wait capture shows up as a `busy` or `done` edge in the wrong clock, and a strobe edge likewise. The bench compares every clock, so such an error is caught within one clock of the misplaced edge. A corrupted phase bit shifts `ale` into the second half and flips `second_half`, which shows up within two clocks. A wrong capture point for read data stays hidden on the bus pins but appears on `rdata` in the closing cycle of the read. The instruction counter is checked through the spacing of `ale` pulses across instructions of different lengths.

// File: rtl/xds_pkg.sv
package xds_pkg;

    // Cycles of a transfer with no wait states: address, two strobe, closing.
    parameter int unsigned XFER_BASE_CYC = 4;

    // Which part of a transfer the next machine cycle belongs to.
    typedef enum logic [1:0] {
        SEG_IDLE,
        SEG_ADDR,
        SEG_STROBE,
        SEG_FINISH
    } seg_e;

endpackage

// File: rtl/xds_waitreg.sv
module xds_waitreg #(
    parameter int                 REG_W    = 8,
    parameter int                 WS_W     = 3,
    parameter logic [REG_W-1:0]   SFR_ADDR = 'h9F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [WS_W-1:0]  wait_cnt
);

    localparam int PAD_W = REG_W - WS_W;

    logic [WS_W-1:0] wait_d, wait_q;

    always_comb begin
        wait_d = wait_q;
        if (we && (addr == SFR_ADDR)) begin
            wait_d = wdata[WS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else begin
            wait_q <= wait_d;
        end
    end

    assign rdata    = {{PAD_W{1'b0}}, wait_q};
    assign wait_cnt = wait_q;

    AST_WAIT_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == SFR_ADDR)) |=> (rdata[WS_W-1:0] == $past(wdata[WS_W-1:0]))); // R9
    AST_WAIT_IGNORES_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || (addr != SFR_ADDR)) |=> $stable(rdata)); // R9

endmodule

// File: rtl/xds_core.sv
module xds_core
    import xds_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WS_W   = 3,
    parameter int LEN_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LEN_W-1:0]         insn_len,
    input  logic                     req,
    input  logic                     req_we,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [WS_W-1:0]          wait_cnt,
    input  logic [DATA_W-1:0]        ad_i,
    output logic                     second_half,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_o,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi
);

    localparam int MAX_CYC = XFER_BASE_CYC + (1 << WS_W) - 1;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic               phase;
        logic               busy;
        logic [CNT_W-1:0]   cyc;
        logic [CNT_W-1:0]   span;
        logic               is_wr;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic [LEN_W-1:0]   rem;
        logic               ale;
        logic               rd_n;
        logic               wr_n;
        logic [DATA_W-1:0]  ad;
        logic               ad_oe;
        logic               done;
    } st_t;

    st_t  d, q;
    seg_e seg;

    always_comb begin
        d       = q;
        seg     = SEG_IDLE;
        d.phase = ~q.phase;
        if (!q.phase) begin
            // Mid-cycle edge: only the latch strobe falls.
            d.ale = 1'b0;
        end else if (q.busy && (q.cyc != q.span)) begin
            d.cyc = q.cyc + 1'b1;
            if (!q.is_wr && (d.cyc == q.span)) begin
                d.rdata = ad_i;
            end
            seg = (d.cyc == q.span) ? SEG_FINISH : SEG_STROBE;
        end else if (!q.busy && req) begin
            d.busy  = 1'b1;
            d.cyc   = CNT_W'(1);
            d.span  = CNT_W'(XFER_BASE_CYC) + CNT_W'(wait_cnt);
            d.is_wr = req_we;
            d.addr  = req_addr;
            d.wdata = req_wdata;
            d.rem   = '0;
            seg     = SEG_ADDR;
        end else begin
            d.busy  = 1'b0;
            d.cyc   = '0;
            d.is_wr = 1'b0;
            d.addr  = '0;
            if (q.rem == '0) begin
                d.ale = 1'b1;
                d.rem = (insn_len > LEN_W'(1)) ? insn_len - 1'b1 : '0;
            end else begin
                d.ale = 1'b0;
                d.rem = q.rem - 1'b1;
            end
        end

        if (q.phase) begin
            unique case (seg)
                SEG_ADDR: begin
                    d.ale   = 1'b1;
                    d.ad    = d.addr[DATA_W-1:0];
                    d.ad_oe = 1'b1;
                    d.rd_n  = 1'b1;
                    d.wr_n  = 1'b1;
                    d.done  = 1'b0;
                end
                SEG_STROBE, SEG_FINISH: begin
                    d.ale   = 1'b0;
                    d.ad    = q.is_wr ? q.wdata : '0;
                    d.ad_oe = q.is_wr;
                    d.rd_n  = (seg == SEG_FINISH) || q.is_wr;
                    d.wr_n  = (seg == SEG_FINISH) || !q.is_wr;
                    d.done  = (seg == SEG_FINISH);
                end
                default: begin
                    d.ad    = '0;
                    d.ad_oe = 1'b0;
                    d.rd_n  = 1'b1;
                    d.wr_n  = 1'b1;
                    d.done  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.rd_n <= 1'b1;
            q.wr_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign second_half = q.phase;
    assign busy        = q.busy;
    assign done        = q.done;
    assign rdata       = q.rdata;
    assign ale         = q.ale;
    assign rd_n        = q.rd_n;
    assign wr_n        = q.wr_n;
    assign ad_o        = q.ad;
    assign ad_oe       = q.ad_oe;
    assign a_hi        = q.addr[ADDR_W-1:DATA_W];

    // Clocks spent busy, for the transfer length check.
    logic [CNT_W:0] chk_ticks;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_ticks <= '0;
        end else begin
            chk_ticks <= q.busy ? chk_ticks + 1'b1 : '0;
        end
    end

    AST_XFER_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> (chk_ticks == {$past(q.span), 1'b0})); // R5
    AST_DONE_BEFORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(q.done)); // R5
    AST_STROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.rd_n || !q.wr_n) |-> q.busy); // R6
    AST_SPAN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |-> $stable(q.span)); // R11
    AST_ALE_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        q.phase |-> !q.ale); // R12
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!q.rd_n && !q.wr_n)); // R12

endmodule

// File: rtl/xdata_sequencer.sv
module xdata_sequencer #(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          WS_W     = 3,
    parameter int          LEN_W    = 3,
    parameter logic [7:0]  SFR_ADDR = 8'h9F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic                     second_half,
    input  logic [LEN_W-1:0]         insn_len,
    input  logic                     req,
    input  logic                     req_we,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    input  logic                     sfr_we,
    input  logic [7:0]               sfr_addr,
    input  logic [7:0]               sfr_wdata,
    output logic [7:0]               sfr_rdata,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_o,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_i,
    output logic [ADDR_W-DATA_W-1:0] a_hi
);

    logic [WS_W-1:0] wait_cnt;

    xds_waitreg #(
        .REG_W    (8),
        .WS_W     (WS_W),
        .SFR_ADDR (SFR_ADDR)
    ) u_waitreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (sfr_we),
        .addr     (sfr_addr),
        .wdata    (sfr_wdata),
        .rdata    (sfr_rdata),
        .wait_cnt (wait_cnt)
    );

    xds_core #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WS_W   (WS_W),
        .LEN_W  (LEN_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_len    (insn_len),
        .req         (req),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .wait_cnt    (wait_cnt),
        .ad_i        (ad_i),
        .second_half (second_half),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata),
        .ale         (ale),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .ad_o        (ad_o),
        .ad_oe       (ad_oe),
        .a_hi        (a_hi)
    );

endmodule

// File: tb/tb_xdata_sequencer.sv
module tb_xdata_sequencer;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        second_half;
    logic [2:0]  insn_len;
    logic        req, req_we;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        busy, done;
    logic [7:0]  rdata;
    logic        sfr_we;
    logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
    logic        ale, rd_n, wr_n, ad_oe;
    logic [7:0]  ad_o, ad_i, a_hi;

    xdata_sequencer dut (
        .clk(clk), .rst_n(rst_n), .second_half(second_half), .insn_len(insn_len),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .a_hi(a_hi)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Behavioural reference: half-cycle phase, transfer index k of tot cycles.
    int          m_ph, m_busy, m_k, m_tot, m_wait, m_rem, m_wr, m_nextwait;
    logic [15:0] m_addr;
    logic [7:0]  m_wd, m_rd;
    logic        m_ale;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_busy = 0; m_k = 0; m_tot = 0; m_wait = 0; m_rem = 0; m_wr = 0;
            m_addr = 0; m_wd = 0; m_rd = 0; m_ale = 0;
        end else begin
            m_nextwait = m_wait;
            if (sfr_we && sfr_addr == 8'h9F) m_nextwait = int'(sfr_wdata) % 8;
            if (m_ph == 0) begin
                m_ph  = 1;
                m_ale = 0;
            end else begin
                m_ph = 0;
                if (m_busy != 0 && m_k < m_tot) begin
                    m_k = m_k + 1;
                    if (m_wr == 0 && m_k == m_tot) m_rd = ad_i;
                    m_ale = 0;
                end else if (m_busy == 0 && req) begin
                    m_busy = 1; m_k = 1; m_tot = 4 + m_wait; m_wr = int'(req_we);
                    m_addr = req_addr; m_wd = req_wdata; m_rem = 0; m_ale = 1;
                end else begin
                    m_busy = 0; m_k = 0;
                    if (m_rem == 0) begin
                        m_ale = 1;
                        m_rem = (insn_len > 1) ? int'(insn_len) - 1 : 0;
                    end else begin
                        m_ale = 0;
                        m_rem = m_rem - 1;
                    end
                end
            end
            m_wait = m_nextwait;
        end
    end

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        logic strobe, e_rd_n, e_wr_n, e_oe, e_done;
        logic [7:0] e_ad, e_hi;
        @(negedge clk);
        strobe = (m_busy != 0) && (m_k >= 2) && (m_k < m_tot);
        e_rd_n = !(strobe && m_wr == 0);
        e_wr_n = !(strobe && m_wr != 0);
        e_oe   = (m_busy != 0) && (m_k == 1 || m_wr != 0);
        e_ad   = (m_busy == 0) ? 8'h00 : (m_k == 1) ? m_addr[7:0] : (m_wr != 0) ? m_wd : 8'h00;
        e_hi   = (m_busy != 0) ? m_addr[15:8] : 8'h00;
        e_done = (m_busy != 0) && (m_k == m_tot);
        chk("R2", "second_half", 16'(second_half), 16'(m_ph));
        chk("R3", "ale", 16'(ale), 16'(m_ale));
        chk("R5", "busy", 16'(busy), 16'(m_busy != 0));
        chk("R5", "done", 16'(done), 16'(e_done));
        chk("R6", "rd_n", 16'(rd_n), 16'(e_rd_n));
        chk("R6", "wr_n", 16'(wr_n), 16'(e_wr_n));
        chk("R6", "a_hi", 16'(a_hi), 16'(e_hi));
        chk("R7", "ad_oe", 16'(ad_oe), 16'(e_oe));
        chk("R7", "ad_o", 16'(ad_o), 16'(e_ad));
        chk("R8", "rdata", 16'(rdata), 16'(m_rd));
        chk("R9", "sfr_rdata", 16'(sfr_rdata), 16'(m_wait));
        chk("R12", "strobe overlap", 16'(!rd_n && !wr_n), 16'd0);
        chk("R12", "ale in second half", 16'(second_half && ale), 16'd0);
    endtask

    task automatic start_req(input logic we, input logic [15:0] a, input logic [7:0] wd);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        while (busy) tick();
        do tick(); while (!busy);
    endtask

    // Counts clocks with busy high; called right after busy was first seen.
    task automatic count_busy(input int ws_new, output int ticks);
        ticks = 1;
        forever begin
            if (ws_new >= 0) begin
                sfr_addr  = 8'h9F;
                sfr_wdata = 8'(ws_new);
                sfr_we    = (ticks == 3);
            end
            tick();
            sfr_we = 1'b0;
            if (!busy) break;
            ticks++;
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] v);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = v;
        tick();
        sfr_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int t, gap;
        rst_n = 1'b0; insn_len = 3'd1; req = 1'b0; req_we = 1'b0; req_addr = '0;
        req_wdata = '0; sfr_we = 1'b0; sfr_addr = '0; sfr_wdata = '0; ad_i = '0;
        repeat (3) @(negedge clk);
        chk("R1", "ale in reset", 16'(ale), 16'd0);
        chk("R1", "rd_n in reset", 16'(rd_n), 16'd1);
        rst_n = 1'b1;
        #1;
        chk("R1", "ale", 16'(ale), 16'd0);
        chk("R1", "rd_n/wr_n", 16'({rd_n, wr_n}), 16'd3);
        chk("R1", "busy/done", 16'({busy, done}), 16'd0);
        chk("R1", "ad_oe/ad_o", 16'({ad_oe, ad_o}), 16'd0);
        chk("R1", "a_hi/rdata", 16'({a_hi, rdata}), 16'd0);
        chk("R1", "sfr_rdata/second_half", 16'({sfr_rdata, second_half}), 16'd0);

        // R3 single-cycle instructions, R4 longer ones and length 0.
        repeat (12) tick();
        insn_len = 3'd3; repeat (20) tick();
        insn_len = 3'd2; repeat (12) tick();
        insn_len = 3'd0; repeat (8) tick();
        insn_len = 3'd1;

        // R7 write, no wait states.
        start_req(1'b1, 16'h12A4, 8'h3C); req = 1'b0;
        count_busy(-1, t);
        chk("R5", "write busy clocks n=0", 16'(t), 16'd8);
        repeat (4) tick();

        // R9 register access.
        sfr_write(8'h9F, 8'hFD); tick();
        chk("R9", "masked wait value", 16'(sfr_rdata), 16'h0005);
        sfr_write(8'h9E, 8'h03); tick();
        chk("R9", "other address ignored", 16'(sfr_rdata), 16'h0005);

        // R8 read with n=5; R11 rewrite to 1 during it.
        ad_i = 8'h96;
        start_req(1'b0, 16'hBEEF, 8'h00); req = 1'b0;
        count_busy(1, t);
        chk("R11", "in-flight length kept n=5", 16'(t), 16'd18);
        chk("R8", "read byte", 16'(rdata), 16'h0096);
        chk("R9", "rewritten wait value", 16'(sfr_rdata), 16'h0001);
        repeat (3) tick();
        ad_i = 8'h21;
        start_req(1'b0, 16'h0102, 8'h00); req = 1'b0;
        count_busy(-1, t);
        chk("R11", "next transfer uses n=1", 16'(t), 16'd10);
        chk("R8", "second read byte", 16'(rdata), 16'h0021);

        // R10 request held during a transfer.
        ad_i = 8'h5E;
        start_req(1'b1, 16'h7F80, 8'hA5);
        req_we = 1'b0; req_addr = 16'h4433;
        count_busy(-1, t);
        chk("R5", "first of pair n=1", 16'(t), 16'd10);
        gap = 1;
        tick();
        while (!busy) begin gap++; tick(); end
        chk("R10", "idle clocks between transfers", 16'(gap), 16'd2);
        req = 1'b0;
        count_busy(-1, t);
        chk("R10", "held read completed", 16'(t), 16'd10);
        chk("R8", "held read byte", 16'(rdata), 16'h005E);

        // Longest stretch, n=7.
        sfr_write(8'h9F, 8'h07);
        start_req(1'b1, 16'hFFFF, 8'h81); req = 1'b0;
        count_busy(-1, t);
        chk("R5", "write busy clocks n=7", 16'(t), 16'd22);
        insn_len = 3'd4; repeat (16) tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule